// File: doc/BRIEF.md
# Programmable Interval Timer with Staged Overflow Reload

This block pairs a free-running divider with an 8-bit programmable counter. Each machine step (a one-cycle `step_en` pulse) advances the divider by one. The counter advances when a chosen divider bit, gated by an enable flag in the control register, goes from 1 to 0. When the counter wraps, it takes the modulo value at once. It then passes through a two-step reload sequence before it returns to normal counting. The interrupt request appears one step after the wrap.

The interrupt request comes with a qualifier, `irq_dly`. This qualifier tells the consumer to ignore the request for one sub-step. There is one exception. A control-register write can create a spurious falling edge on the selected divider bit, and that edge adds one extra count. If this extra count causes the wrap, the request that follows is not qualified as delayed. A write to the divider clears it, and that can also create a falling edge.

A host uses the block through a write port and a combinational read port. Register addresses: 0 is the divider (reads return its top 8 bits), 1 is the counter, 2 is the modulo, and 3 is the control register.

Top module: `tmr_unit`

## Requirements
- R1: Each step adds one to the divider. A read at address 0 returns divider bits [15:8]. A write to address 0 clears the whole divider to zero.
- R2: The counter increments once each time the value (control bit 2 AND a selected divider bit) falls from 1 to 0. The selected bit depends on control bits [1:0]: value 1 selects divider bit 1, value 2 selects bit 3, value 3 selects bit 5, and value 0 selects bit 7. With control bit 2 clear, steps never increment the counter.
- R3: An increment from 0xFF loads the modulo value into the counter in that same cycle, and no interrupt request is raised then.
- R4: On the next step after such a wrap, `irq_req` rises together with `irq_dly`. Both hold until the following step, which clears them.
- R5: One step after the request, the reload sequence is over, and a counter write takes effect normally again.
- R6: A control write makes one extra increment when the old value (enable AND selected bit) is 1 and the value computed with the new control byte is 0.
- R7: When that extra control-write increment causes the wrap, the later request comes with `irq_dly` low.
- R8: A divider write made while (enable AND selected bit) is 1 makes one extra increment. A wrap caused by it gives a delayed request, with `irq_dly` high.
- R9: A counter write between the wrap and the next step cancels the reload. The counter takes the written value, and no request is raised at the next step.
- R10: A counter write between the request step and the step after it is ignored, so the counter keeps the reloaded value.
- R11: A modulo write in that same window also loads the written value into the counter.
- R12: After reset, all four registers read zero, and `irq_req` and `irq_dly` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_en | input | 1 | One-cycle pulse per machine step |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 divider, 1 counter, 2 modulo, 3 control) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address, same map |
| rd_data | output | 8 | Read data, combinational |
| irq_req | output | 1 | Timer interrupt request, held for one step |
| irq_dly | output | 1 | Request is delayed by one sub-step |

## Verification
The checks assume that a register write never falls in the same cycle as a step pulse. The reload-window properties also rely on the fact that the fastest tap cannot fall on two steps in a row. The stimulus keeps to this rule: each cycle carries either a step or a write, never both. Writes happen between steps. The random register data is biased toward values near 0xFF, so that both normal wraps and wraps caused by control writes occur often.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   typedef enum logic [1:0] {
      TS_RUN     = 2'd0,
      TS_LOADING = 2'd1,
      TS_LOADED  = 2'd2
   } tstate_e;

   localparam logic [1:0] A_DIV = 2'd0;
   localparam logic [1:0] A_CNT = 2'd1;
   localparam logic [1:0] A_MOD = 2'd2;
   localparam logic [1:0] A_CTL = 2'd3;

   // Divider bit watched for select code sel: code 0 takes the slowest tap.
   function automatic int tap_pos(input int sel, input int nsel, input int lo);
      return lo + 2 * ((sel + nsel - 1) % nsel);
   endfunction

endpackage

// File: rtl/tmr_divider.sv
module tmr_divider #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_en,
   input  logic             clr,
   output logic [DIV_W-1:0] div_q,
   output logic [DIV_W-1:0] div_nx
);

   generate
      if (DIV_W < 4) begin : g_bad_w
         $error("tmr_divider: DIV_W too small");
      end
   endgenerate

   always_comb begin
      if (step_en)  div_nx = div_q + 1'b1;
      else if (clr) div_nx = '0;
      else          div_nx = div_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) div_q <= '0;
      else        div_q <= div_nx;
   end

   // R1
   div_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step_en |=> div_q == $past(div_q) + 1'b1);

   // R1
   div_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !step_en) |=> div_q == '0);

endmodule

// File: rtl/tmr_tap_sel.sv
module tmr_tap_sel #(
   parameter int DIV_W  = 16,
   parameter int SEL_W  = 2,
   parameter int TAP_LO = 1,
   parameter int CTL_W  = SEL_W + 1,
   parameter int EN_BIT = SEL_W
) (
   input  logic [CTL_W-1:0] ctl,
   input  logic [DIV_W-1:0] div,
   output logic             sig
);

   localparam int NSEL    = 1 << SEL_W;
   localparam int TAP_MAX = TAP_LO + 2 * (NSEL - 1);

   logic [NSEL-1:0] tapv;
   logic            unused_bits;

   generate
      if (TAP_MAX >= DIV_W) begin : g_bad_tap
         $error("tmr_tap_sel: highest tap lies outside the divider");
      end
      if (EN_BIT < SEL_W || EN_BIT >= CTL_W) begin : g_bad_en
         $error("tmr_tap_sel: enable bit overlaps select field");
      end
      for (genvar g = 0; g < NSEL; g++) begin : g_tap
         localparam int TP = tmr_pkg::tap_pos(g, NSEL, TAP_LO);
         assign tapv[g] = div[TP];
      end
   endgenerate

   assign unused_bits = ^div;
   assign sig = ctl[EN_BIT] & tapv[ctl[SEL_W-1:0]];

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
   import tmr_pkg::*;
#(
   parameter int CNT_W = 8,
   parameter int CTL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_en,
   input  logic             wr_ok,
   input  logic [1:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] mod_q,
   output logic [CTL_W-1:0] ctl_q,
   output logic             irq_req,
   output logic             irq_dly
);

   generate
      if (CTL_W >= CNT_W) begin : g_bad_ctl
         $error("tmr_counter: control field wider than data path");
      end
   endgenerate

   tstate_e          st_q, st_n;
   logic [CNT_W-1:0] cnt_n, mod_n;
   logic [CTL_W-1:0] ctl_n;
   logic             nd_q, nd_n;
   logic             irq_q, irq_n, dly_q, dly_n;
   logic             glitch;

   assign glitch = wr_ok && (wr_addr == A_CTL);

   always_comb begin
      st_n  = st_q;
      cnt_n = cnt_q;
      mod_n = mod_q;
      ctl_n = ctl_q;
      nd_n  = nd_q;
      irq_n = irq_q;
      dly_n = dly_q;
      if (step_en) begin
         irq_n = 1'b0;
         dly_n = 1'b0;
         if (st_q == TS_LOADING) begin
            irq_n = 1'b1;
            dly_n = ~nd_q;
            st_n  = TS_LOADED;
         end else if (st_q == TS_LOADED) begin
            st_n = TS_RUN;
         end
      end else if (wr_ok) begin
         case (wr_addr)
            A_CNT: begin
               if (st_q == TS_LOADING) begin
                  cnt_n = wr_data;
                  st_n  = TS_RUN;
               end else if (st_q != TS_LOADED) begin
                  cnt_n = wr_data;
               end
            end
            A_MOD: begin
               mod_n = wr_data;
               if (st_q == TS_LOADED) cnt_n = wr_data;
            end
            A_CTL:   ctl_n = wr_data[CTL_W-1:0];
            default: ;
         endcase
      end
      if (tick) begin
         if (&cnt_q) begin
            cnt_n = mod_q;
            st_n  = TS_LOADING;
            nd_n  = glitch;
         end else begin
            cnt_n = cnt_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= TS_RUN;
         cnt_q <= '0;
         mod_q <= '0;
         ctl_q <= '0;
         nd_q  <= 1'b0;
         irq_q <= 1'b0;
         dly_q <= 1'b0;
      end else begin
         st_q  <= st_n;
         cnt_q <= cnt_n;
         mod_q <= mod_n;
         ctl_q <= ctl_n;
         nd_q  <= nd_n;
         irq_q <= irq_n;
         dly_q <= dly_n;
      end
   end

   assign irq_req = irq_q;
   assign irq_dly = dly_q;

   // R3
   ovf_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && tick && (&cnt_q) && st_q == TS_RUN)
         |=> (cnt_q == $past(mod_q) && !irq_req));

   // R4
   irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && st_q == TS_LOADING) |=> (irq_req && st_q == TS_LOADED));

   // R4
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !step_en |=> $stable(irq_req));

   // R7
   dly_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_dly |-> irq_req);

   // R10
   loaded_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && !step_en && wr_addr == A_CNT && st_q == TS_LOADED && !tick)
         |=> $stable(cnt_q));

endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
   import tmr_pkg::*;
#(
   parameter int DIV_W  = 16,
   parameter int CNT_W  = 8,
   parameter int SEL_W  = 2,
   parameter int TAP_LO = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_en,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   input  logic [1:0]       rd_addr,
   output logic [CNT_W-1:0] rd_data,
   output logic             irq_req,
   output logic             irq_dly
);

   localparam int CTL_W  = SEL_W + 1;
   localparam int EN_BIT = SEL_W;

   generate
      if (DIV_W < CNT_W) begin : g_bad_div
         $error("tmr_unit: divider narrower than data path");
      end
   endgenerate

   logic [DIV_W-1:0] div_q, div_nx;
   logic [CNT_W-1:0] cnt_q, mod_q;
   logic [CTL_W-1:0] ctl_q, ctl_nx;
   logic             wr_ok, sig_now, sig_nx, tick;

   assign wr_ok  = wr_en && !step_en;
   assign ctl_nx = (wr_ok && wr_addr == A_CTL) ? wr_data[CTL_W-1:0] : ctl_q;

   tmr_divider #(.DIV_W(DIV_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .step_en (step_en),
      .clr     (wr_ok && wr_addr == A_DIV),
      .div_q   (div_q),
      .div_nx  (div_nx)
   );

   tmr_tap_sel #(.DIV_W(DIV_W), .SEL_W(SEL_W), .TAP_LO(TAP_LO),
                 .CTL_W(CTL_W), .EN_BIT(EN_BIT)) u_sel_now (
      .ctl (ctl_q),
      .div (div_q),
      .sig (sig_now)
   );

   tmr_tap_sel #(.DIV_W(DIV_W), .SEL_W(SEL_W), .TAP_LO(TAP_LO),
                 .CTL_W(CTL_W), .EN_BIT(EN_BIT)) u_sel_nx (
      .ctl (ctl_nx),
      .div (div_nx),
      .sig (sig_nx)
   );

   assign tick = sig_now & ~sig_nx;

   tmr_counter #(.CNT_W(CNT_W), .CTL_W(CTL_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .step_en (step_en),
      .wr_ok   (wr_ok),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .tick    (tick),
      .cnt_q   (cnt_q),
      .mod_q   (mod_q),
      .ctl_q   (ctl_q),
      .irq_req (irq_req),
      .irq_dly (irq_dly)
   );

   always_comb begin
      case (rd_addr)
         A_DIV:   rd_data = div_q[DIV_W-1 -: CNT_W];
         A_CNT:   rd_data = cnt_q;
         A_MOD:   rd_data = mod_q;
         default: rd_data = {{(CNT_W-CTL_W){1'b0}}, ctl_q};
      endcase
   end

   // input rule: writes are placed between steps
   no_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && step_en));

   // R12
   rst_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> (!irq_req && !irq_dly && cnt_q == '0));

endmodule

// File: tb/tmr_unit_tb.sv
`timescale 1ns/1ps
module tmr_unit_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       step_en = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = 2'd0;
   logic [7:0] wr_data = 8'd0;
   logic [1:0] rd_addr = 2'd0;
   logic [7:0] rd_data;
   logic       irq_req, irq_dly;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   tmr_unit dut_i (
      .clk(clk), .rst_n(rst_n), .step_en(step_en), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .irq_req(irq_req), .irq_dly(irq_dly)
   );

   // reference state built from the requirements
   logic [15:0] m_div;
   logic [7:0]  m_cnt, m_mod;
   logic [2:0]  m_ctl;
   int          m_st;      // 0 counting, 1 after wrap, 2 after request
   bit          m_nd, m_irq, m_dly;

   function automatic int tap_of(input logic [1:0] s);
      case (s)
         2'd0: return 7;
         2'd1: return 1;
         2'd2: return 3;
         default: return 5;
      endcase
   endfunction

   function automatic bit sel_sig(input logic [2:0] c, input logic [15:0] d);
      return c[2] & d[tap_of(c[1:0])];
   endfunction

   task automatic m_inc(input bit g);
      if (m_cnt == 8'hFF) begin
         m_cnt = m_mod; m_st = 1; m_nd = g;
      end else begin
         m_cnt = m_cnt + 8'd1;
      end
   endtask

   task automatic m_reset();
      m_div = '0; m_cnt = '0; m_mod = '0; m_ctl = '0;
      m_st = 0; m_nd = 0; m_irq = 0; m_dly = 0;
   endtask

   task automatic m_update(input bit st, input bit wr, input logic [1:0] a, input logic [7:0] d);
      bit old_s, new_s;
      old_s = sel_sig(m_ctl, m_div);
      if (st) begin
         m_irq = 0; m_dly = 0;
         if (m_st == 1) begin m_irq = 1; m_dly = !m_nd; m_st = 2; end
         else if (m_st == 2) m_st = 0;
         m_div = m_div + 16'd1;
         new_s = sel_sig(m_ctl, m_div);
         if (old_s && !new_s) m_inc(0);
      end else if (wr) begin
         case (a)
            2'd0: begin m_div = '0; if (old_s) m_inc(0); end
            2'd1: begin
               if (m_st == 1) begin m_cnt = d; m_st = 0; end
               else if (m_st != 2) m_cnt = d;
            end
            2'd2: begin m_mod = d; if (m_st == 2) m_cnt = d; end
            default: begin
               new_s = sel_sig(d[2:0], m_div);
               m_ctl = d[2:0];
               if (old_s && !new_s) m_inc(1);
            end
         endcase
      end
   endtask

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // called just after a falling edge; returns just after the next falling edge
   task automatic cyc(input bit st, input bit wr, input logic [1:0] a, input logic [7:0] d);
      step_en = st; wr_en = wr; wr_addr = a; wr_data = d;
      @(posedge clk);
      m_update(st, wr, a, d);
      @(negedge clk);
      step_en = 0; wr_en = 0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] v);
      rd_addr = a; #1; v = rd_data;
   endtask

   task automatic cmp_all(input string tag_div, input string tag_cnt, input string tag_irq);
      logic [7:0] v;
      rd(2'd0, v); check(tag_div, v, m_div[15:8]);
      rd(2'd1, v); check(tag_cnt, v, m_cnt);
      rd(2'd2, v); check(tag_cnt, v, m_mod);
      rd(2'd3, v); check(tag_cnt, v, {5'd0, m_ctl});
      check(tag_irq, irq_req, m_irq);
      check(tag_irq, irq_dly, m_dly);
   endtask

   task automatic do_reset();
      step_en = 0; wr_en = 0;
      rst_n = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
      m_reset();
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      cyc(0, 1, a, d);
   endtask

   task automatic stp();
      cyc(1, 0, 2'd0, 8'd0);
   endtask

   // enable with fastest tap, counter one below wrap, then four steps to the wrap
   task automatic to_wrap(input logic [7:0] modv);
      do_reset();
      wr(2'd3, 8'h05);
      wr(2'd2, modv);
      wr(2'd1, 8'hFF);
      repeat (4) stp();
   endtask

   initial begin
      logic [7:0] v;
      void'($urandom(32'd20240611));
      @(negedge clk);
      do_reset();

      // R12 reset values
      rd(2'd0, v); check("R12 div", v, 0);
      rd(2'd1, v); check("R12 cnt", v, 0);
      rd(2'd2, v); check("R12 mod", v, 0);
      rd(2'd3, v); check("R12 ctl", v, 0);
      check("R12 irq", irq_req, 0);
      check("R12 dly", irq_dly, 0);

      // R2 tap periods: first increment after 2^(tap+1) steps
      for (int s = 0; s < 4; s++) begin
         int n;
         do_reset();
         wr(2'd3, 8'(4 + s));
         n = 1 << (tap_of(2'(s)) + 1);
         repeat (n - 1) stp();
         rd(2'd1, v); check("R2 before edge", v, 0);
         stp();
         rd(2'd1, v); check("R2 at edge", v, 1);
      end
      do_reset();
      wr(2'd3, 8'h01);
      repeat (8) stp();
      rd(2'd1, v); check("R2 disabled", v, 0);

      // R1 divider read and clear
      do_reset();
      repeat (300) stp();
      rd(2'd0, v); check("R1 div top", v, 1);
      wr(2'd0, 8'h9C);
      rd(2'd0, v); check("R1 div clear", v, 0);

      // R3 / R4 / R5 normal wrap
      to_wrap(8'h40);
      rd(2'd1, v); check("R3 reload", v, 8'h40);
      check("R3 no irq yet", irq_req, 0);
      stp();
      check("R4 irq rise", irq_req, 1);
      check("R4 dly", irq_dly, 1);
      cyc(0, 0, 2'd0, 8'd0);
      check("R4 irq hold", irq_req, 1);
      stp();
      check("R4 irq clear", irq_req, 0);
      check("R4 dly clear", irq_dly, 0);
      wr(2'd1, 8'h10);
      rd(2'd1, v); check("R5 write after sequence", v, 8'h10);

      // R9 cancel
      to_wrap(8'h40);
      wr(2'd1, 8'h33);
      stp();
      check("R9 no irq", irq_req, 0);
      rd(2'd1, v); check("R9 cnt", v, 8'h33);

      // R10 / R11
      to_wrap(8'h40);
      stp();
      wr(2'd1, 8'h77);
      rd(2'd1, v); check("R10 ignored", v, 8'h40);
      wr(2'd2, 8'h5A);
      rd(2'd1, v); check("R11 mod into cnt", v, 8'h5A);

      // R6 / R7 control glitch wrap
      do_reset();
      wr(2'd3, 8'h05);
      wr(2'd2, 8'h11);
      wr(2'd1, 8'hFF);
      repeat (3) stp();
      wr(2'd3, 8'h01);
      rd(2'd1, v); check("R6 glitch reload", v, 8'h11);
      check("R6 no irq yet", irq_req, 0);
      stp();
      check("R7 irq", irq_req, 1);
      check("R7 not delayed", irq_dly, 0);

      // R8 divider-write wrap
      do_reset();
      wr(2'd3, 8'h05);
      wr(2'd2, 8'h22);
      wr(2'd1, 8'hFF);
      repeat (2) stp();
      wr(2'd0, 8'h00);
      rd(2'd1, v); check("R8 div write reload", v, 8'h22);
      rd(2'd0, v); check("R1 div cleared", v, 0);
      stp();
      check("R8 irq", irq_req, 1);
      check("R8 delayed", irq_dly, 1);

      // random mix against the reference
      do_reset();
      for (int i = 0; i < 4000; i++) begin
         int r;
         logic [1:0] a;
         logic [7:0] d;
         r = $urandom % 8;
         a = 2'($urandom % 4);
         if (a == 2'd0 && ($urandom % 4) != 0) a = 2'd3;
         d = (($urandom % 3) == 0) ? (8'hFC | 8'($urandom % 4)) : 8'($urandom);
         if (r < 5) cyc(1, 0, 2'd0, 8'd0);
         else if (r < 7) cyc(0, 1, a, d);
         else cyc(0, 0, 2'd0, 8'd0);
         cmp_all("R1", "R2", "R4/R7");
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule